// File: doc/BRIEF.md
# Long-Range Decrementing Timer

This block is a down-counting interval timer for very long delays. While its enable input is held high it counts its present value down by one unit on every 0.1 s tick strobe, starting from a 32-bit set value. When the count reaches zero it raises a completion flag and holds the count at zero. Dropping the enable abandons the interval: the present value goes back to the set value and the flag clears.

The count format is fixed by a parameter. In decimal mode the 32-bit word holds eight BCD digits, so the longest interval is 99,999,999 tenths of a second, about 115 days. In binary mode the full word is used, so the longest interval is about 4,971 days. The tick strobe comes from outside the block. The system integrator derives it from the clock with a prescaler of their choice.

Top module: `long_timer`

## Requirements
- R1: While rst_n is low at a clock edge, the timer clears its present value to 0 and its done flag to 0.
- R2: At every clock edge where run_en is low, present_value takes the loaded form of set_value and done clears to 0. Ticks have no effect while run_en is low.
- R3: At the first clock edge where run_en is high after being low, present_value loads the loaded form of set_value and done is 0. A tick in that cycle is ignored, so counting starts with the next tick.
- R4: At a later clock edge with run_en still high, a nonzero count drops by exactly one unit if tick_100ms is high and is unchanged if tick_100ms is low.
- R5: In decimal mode, each 4-bit nibble of present_value is one decimal digit, with bits [3:0] the least significant. Decrementing a digit at 0 makes it 9 and borrows from the next higher digit, so 0x00001000 becomes 0x00000999.
- R6: done goes high on the same edge at which present_value becomes 0. With a set value of 0, done goes high at the edge after the loading edge.
- R7: While run_en stays high, a count of zero never wraps. present_value stays 0 and done stays 1 whatever ticks arrive.
- R8: In decimal mode, the loaded form of set_value replaces any nibble above 9 by 9, so 0x1A3F0099 loads as 0x19390099. In binary mode the set value loads unchanged.
- R9: MODE selects the count format. CNT_BCD counts eight decimal digits, a maximum of 99,999,999 units. CNT_BINARY counts the full 32-bit word, so 0x10000000 decrements to 0x0FFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_100ms | input | 1 | One-cycle strobe marking each 0.1 s unit |
| run_en | input | 1 | Timer enable; low resets the interval |
| set_value | input | 32 | Interval length in 0.1 s units (BCD or binary per MODE) |
| present_value | output | 32 | Remaining count |
| done | output | 1 | Completion flag |

## Verification
Every result is due exactly one clock edge after the inputs that cause it. This covers the loads while disabled, the load on the enable rising edge, each decrement and the done flag, because one register stage holds the count, the flag and the delayed enable. The bench drives inputs on the falling edge and steps one rising edge. It then compares at the next falling edge against a model updated for that edge, so every check looks at the cycle its result is due. Two instances, one per mode, share the stimulus. This lets a single sweep compare the decimal and binary counts, including the cycles where a tick must be ignored.

// File: rtl/lt_pkg.sv
// Package: shared definitions for the long-range timer.
// Assumes: the count word is a whole number of 4-bit digits.
package lt_pkg;
    localparam int DIGIT_W = 4;

    typedef enum logic {
        CNT_BINARY = 1'b0,
        CNT_BCD    = 1'b1
    } cnt_mode_e;
endpackage

// File: rtl/lt_load_fix.sv
// Module: forms the value loaded into the count from the set value.
// In decimal mode each nibble above 9 is forced to 9; in binary mode the
// value passes through. Pure combinational logic.
module lt_load_fix
    import lt_pkg::*;
#(
    parameter cnt_mode_e MODE = CNT_BCD,
    parameter int        W    = 32
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] fixed
);
    localparam int NDIG = W / DIGIT_W;

    generate
        if (MODE == CNT_BCD) begin : g_dec
            for (genvar i = 0; i < NDIG; i++) begin : g_dig
                // Clamp one nibble to the decimal range.
                always_comb begin
                    if (raw[i*DIGIT_W +: DIGIT_W] > 4'd9)
                        fixed[i*DIGIT_W +: DIGIT_W] = 4'd9;
                    else
                        fixed[i*DIGIT_W +: DIGIT_W] = raw[i*DIGIT_W +: DIGIT_W];
                end
            end
        end else begin : g_bin
            // Binary counts take the set value unchanged.
            always_comb fixed = raw;
        end
    endgenerate
endmodule

// File: rtl/lt_dec_step.sv
// Module: one-unit decrement of the count word.
// Decimal mode uses a ripple borrow across digits; binary mode subtracts 1.
// Assumes the caller uses the result only for a nonzero input.
module lt_dec_step
    import lt_pkg::*;
#(
    parameter cnt_mode_e MODE = CNT_BCD,
    parameter int        W    = 32
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    localparam int NDIG = W / DIGIT_W;

    generate
        if (MODE == CNT_BCD) begin : g_dec
            logic [NDIG:0] borrow;
            assign borrow[0] = 1'b1;
            for (genvar i = 0; i < NDIG; i++) begin : g_dig
                logic [DIGIT_W-1:0] d;
                assign d = cur[i*DIGIT_W +: DIGIT_W];
                // Digit update: 0 under borrow becomes 9 and passes the borrow on.
                always_comb begin
                    if (!borrow[i])
                        nxt[i*DIGIT_W +: DIGIT_W] = d;
                    else if (d == '0)
                        nxt[i*DIGIT_W +: DIGIT_W] = 4'd9;
                    else
                        nxt[i*DIGIT_W +: DIGIT_W] = d - 1'b1;
                end
                assign borrow[i+1] = borrow[i] && (d == '0);
            end
        end else begin : g_bin
            // Plain binary decrement.
            always_comb nxt = cur - 1'b1;
        end
    endgenerate
endmodule

// File: rtl/long_timer.sv
// Module: long-range decrementing timer (top).
// Counts set_value down one unit per tick while run_en is high, flags zero,
// and holds at zero. Low run_en reloads the count and clears the flag.
// Assumes tick_100ms is a single-cycle strobe synchronous to clk.
module long_timer
    import lt_pkg::*;
#(
    parameter cnt_mode_e MODE = CNT_BCD,
    parameter int        W    = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_100ms,
    input  logic         run_en,
    input  logic [W-1:0] set_value,
    output logic [W-1:0] present_value,
    output logic         done
);
    localparam int NDIG = W / DIGIT_W;

    logic [W-1:0] load_val;
    logic [W-1:0] dec_val;
    logic [W-1:0] cnt_next;
    logic         en_q;
    logic         steady;

    lt_load_fix #(.MODE(MODE), .W(W)) u_fix (
        .raw   (set_value),
        .fixed (load_val)
    );

    lt_dec_step #(.MODE(MODE), .W(W)) u_dec (
        .cur (present_value),
        .nxt (dec_val)
    );

    // Enable held since the previous edge: counting may proceed.
    assign steady = run_en && en_q;

    // Next count while steady: step on a tick unless already at zero.
    always_comb begin
        if (tick_100ms && (present_value != '0))
            cnt_next = dec_val;
        else
            cnt_next = present_value;
    end

    // Count, completion flag and enable history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            present_value <= '0;
            done          <= 1'b0;
            en_q          <= 1'b0;
        end else begin
            en_q <= run_en;
            if (!steady) begin
                present_value <= load_val;
                done          <= 1'b0;
            end else begin
                present_value <= cnt_next;
                done          <= (cnt_next == '0);
            end
        end
    end

    // R2: disabled cycles leave the flag clear.
    a_r2_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !done);

    // R4: no tick while steady keeps the count.
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && en_q && !tick_100ms) |=> $stable(present_value));

    // R6: the flag only accompanies a zero count.
    a_r6_done_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (present_value == '0));

    // R7: zero never wraps while enable is held.
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && en_q && present_value == '0) |=> (present_value == '0));

    generate
        if (MODE == CNT_BCD) begin : g_chk_dec
            for (genvar i = 0; i < NDIG; i++) begin : g_dig
                // R5 / R8: every digit stays decimal.
                a_r5_digit_legal: assert property (@(posedge clk) disable iff (!rst_n)
                    present_value[i*DIGIT_W +: DIGIT_W] <= 4'd9);
            end
        end else begin : g_chk_bin
            // R9: a binary tick removes exactly one.
            a_r9_bin_step: assert property (@(posedge clk) disable iff (!rst_n)
                (run_en && en_q && tick_100ms && present_value != '0)
                |=> (present_value == $past(present_value) - 1'b1));
        end
    endgenerate
endmodule

// File: tb/sim_long_timer.sv
// Bench: drives a decimal and a binary instance with shared stimulus and
// compares both against an arithmetic model, one edge per step.
module sim_long_timer;
    import lt_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_100ms;
    logic        run_en;
    logic [31:0] set_value;
    logic [31:0] pv_d, pv_b;
    logic        dn_d, dn_b;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    longint      m_dec;
    logic [31:0] m_bin;
    logic        m_dd, m_db, m_en;

    always #10 clk = ~clk;

    long_timer #(.MODE(CNT_BCD), .W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_100ms(tick_100ms), .run_en(run_en),
        .set_value(set_value), .present_value(pv_d), .done(dn_d)
    );

    long_timer #(.MODE(CNT_BINARY), .W(32)) u1 (
        .clk(clk), .rst_n(rst_n), .tick_100ms(tick_100ms), .run_en(run_en),
        .set_value(set_value), .present_value(pv_b), .done(dn_b)
    );

    function automatic longint dec_of(input logic [31:0] raw);
        longint v = 0;
        for (int i = 7; i >= 0; i--) begin
            int d = int'(raw[i*4 +: 4]);
            if (d > 9) d = 9;
            v = v * 10 + d;
        end
        return v;
    endfunction

    function automatic logic [31:0] to_bcd(input longint v);
        logic [31:0] r = '0;
        longint t = v;
        for (int i = 0; i < 8; i++) begin
            r[i*4 +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    task automatic check(input string req);
        total++;
        if (pv_d !== to_bcd(m_dec) || dn_d !== m_dd) begin
            bad++;
            $display("FAIL %s decimal: pv=%h done=%b expected pv=%h done=%b",
                     req, pv_d, dn_d, to_bcd(m_dec), m_dd);
        end
        total++;
        if (pv_b !== m_bin || dn_b !== m_db) begin
            bad++;
            $display("FAIL %s binary: pv=%h done=%b expected pv=%h done=%b",
                     req, pv_b, dn_b, m_bin, m_db);
        end
    endtask

    // One clock edge: inputs set at the falling edge, checked at the next.
    task automatic step(input logic en, input logic tk, input string req);
        run_en     = en;
        tick_100ms = tk;
        @(posedge clk);
        if (!rst_n) begin
            m_dec = 0; m_bin = '0; m_dd = 0; m_db = 0; m_en = 0;
        end else begin
            if (!en || !m_en) begin
                m_dec = dec_of(set_value); m_bin = set_value;
                m_dd = 0; m_db = 0;
            end else begin
                if (tk && m_dec != 0) m_dec = m_dec - 1;
                if (tk && m_bin != 0) m_bin = m_bin - 1;
                m_dd = (m_dec == 0);
                m_db = (m_bin == 0);
            end
            m_en = en;
        end
        @(negedge clk);
        check(req);
    endtask

    initial begin
        #(20 * 150000);
        if (!ended) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; run_en = 0; tick_100ms = 0; set_value = 32'h0000_0042;
        @(negedge clk);
        // R1: reset state
        step(0, 1, "R1");
        step(1, 1, "R1");
        rst_n = 1;

        // R8 / R2: clamp while disabled, ticks ignored
        set_value = 32'h1A3F_0099;
        step(0, 1, "R8");
        step(0, 0, "R2");
        set_value = 32'h0000_0500;
        step(0, 1, "R2");

        // R3: rise loads, tick ignored; then full countdown
        set_value = 32'h0000_0123;
        step(1, 1, "R3");
        for (int n = 0; n < 300; n++) step(1, 1, "R4 R5 R6");
        // R7: stays at zero with done high
        for (int n = 0; n < 4; n++) step(1, 1, "R7");
        // R2: dropping enable clears done and reloads
        step(0, 0, "R2");

        // R4 / R5: prescaled ticks, borrow 1000 -> 999
        set_value = 32'h0000_1000;
        step(1, 0, "R3");
        for (int n = 0; n < 40; n++) step(1, (n % 5) == 4, "R4 R5");

        // R6: zero set value flags one edge after loading
        set_value = 32'h0;
        step(0, 0, "R2");
        step(1, 0, "R6");
        step(1, 0, "R6");
        step(1, 1, "R7");

        // R9 / R5: borrow across every digit
        set_value = 32'h1000_0000;
        step(0, 0, "R9");
        step(1, 0, "R3");
        step(1, 1, "R9 R5");
        step(1, 0, "R4");
        step(1, 1, "R9");

        // R9: largest decimal count
        set_value = 32'h9999_9999;
        step(0, 0, "R9");
        step(1, 1, "R3");
        step(1, 1, "R9");

        ended = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule